// File: doc/BRIEF.md
# Accumulator Bit Permute Shifter

This block holds a three-part accumulator chain: an 8-bit extension word on top, a 32-bit high word, and a 32-bit low word. Each accepted command moves the whole chain six places toward the top. Six bits leave the top of the low word and enter the high word. Six bits leave the top of the high word and enter the extension word. The top six bits of the extension word are dropped.

The six positions this opens at the bottom of the low word are filled by a gather from the `cmd_src` operand. The `cmd_sel` operand holds six 5-bit indices, one per filled position. Each index picks one bit of `cmd_src`. Repeated commands build a permuted copy of source bits in the accumulator, six bits at a time. The chain contents are visible at all times on the outputs. Instruction decode and every other accumulator operation sit outside the block.

Top module: `acc_perm_shifter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets `ext_q`, `hi_q` and `lo_q` to zero, and takes priority over `cmd_valid`.
- R2: On an edge where `cmd_valid` is low and reset is inactive, all three outputs keep their values.
- R3: On an accepted command, the new `ext_q` is the old `ext_q` shifted up by six with the upper bits discarded, and its bits [5:0] take the old `hi_q[31:26]`.
- R4: On an accepted command, the new `hi_q[31:6]` is the old `hi_q[25:0]`, and the new `hi_q[5:0]` is the old `lo_q[31:26]`.
- R5: On an accepted command, the new `lo_q[31:6]` is the old `lo_q[25:0]`.
- R6: On an accepted command, the new `lo_q` bit i (for i = 0 to 5) equals `cmd_src[k]`, where k is the unsigned value of `cmd_sel[5*i+4:5*i]`. Index value k selects bit k, counting from bit 0 as the least significant bit.
- R7: `cmd_sel[31:30]` has no effect on any output.
- R8: All three words update on the same rising edge that samples the command, and the new values are visible on the outputs straight after that edge. Back-to-back commands each take effect in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe; one permute-shift per cycle it is high |
| cmd_src | input | 32 | Operand whose bits are gathered |
| cmd_sel | input | 32 | Six packed 5-bit bit indices in bits [29:0] |
| ext_q | output | 8 | Extension word of the chain |
| hi_q | output | 32 | High word of the chain |
| lo_q | output | 32 | Low word of the chain |

## Verification
The embedded properties check on every cycle that reset clears the chain, that idle cycles hold it, and that each word picks up the six bits that leave the word below it. They also check that the low six bits of the low word match what the gather logic produced one cycle earlier. Whether the gather reads the correct source bit for each index cannot be shown by those properties. That includes the bit-numbering convention, the boundary indices 0 and 31, and the unused top selector bits. The bench's reference model and its directed patterns cover these, together with a run of five back-to-back permutes, a reset in the middle of a run, and a random stream.

// File: rtl/acc_perm_pkg.sv
package acc_perm_pkg;
  // Default geometry of the accumulator chain.
  localparam int DEF_ACC_W = 32;  // width of high and low words
  localparam int DEF_EXT_W = 8;   // width of the extension word
  localparam int DEF_LANES = 6;   // bits gathered (and shift distance) per command
endpackage

// File: rtl/perm_lane.sv
// One gather lane: returns the source bit addressed by its index field.
module perm_lane #(
  parameter int SRC_W = 32,
  parameter int IDX_W = $clog2(SRC_W)
) (
  input  logic [SRC_W-1:0] src,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_out
);
  function automatic logic pick(input logic [SRC_W-1:0] s, input logic [IDX_W-1:0] k);
    return s[k];
  endfunction

  assign bit_out = pick(src, idx);
endmodule

// File: rtl/perm_gather.sv
// Bank of gather lanes; lane i reads index field i of the selector.
module perm_gather #(
  parameter int ACC_W = 32,
  parameter int LANES = 6
) (
  input  logic [ACC_W-1:0] src,
  input  logic [ACC_W-1:0] sel,
  output logic [LANES-1:0] bits
);
  localparam int IDX_W = $clog2(ACC_W);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] lane_idx;
    assign lane_idx = IDX_W'(sel >> (g * IDX_W));
    perm_lane #(.SRC_W(ACC_W), .IDX_W(IDX_W)) u_lane (
      .src    (src),
      .idx    (lane_idx),
      .bit_out(bits[g])
    );
  end
endmodule

// File: rtl/acc_chain_shift.sv
// Next-state of the chain: every word moves up by SHIFT, fed from the word below.
module acc_chain_shift #(
  parameter int ACC_W = 32,
  parameter int EXT_W = 8,
  parameter int SHIFT = 6
) (
  input  logic [EXT_W-1:0] ext_cur,
  input  logic [ACC_W-1:0] hi_cur,
  input  logic [ACC_W-1:0] lo_cur,
  input  logic [SHIFT-1:0] fill,
  output logic [EXT_W-1:0] ext_nxt,
  output logic [ACC_W-1:0] hi_nxt,
  output logic [ACC_W-1:0] lo_nxt
);
  // Top SHIFT bits of a word, right-aligned.
  function automatic logic [ACC_W-1:0] top_out(input logic [ACC_W-1:0] w);
    return w >> (ACC_W - SHIFT);
  endfunction

  function automatic logic [ACC_W-1:0] word_step(input logic [ACC_W-1:0] w,
                                                  input logic [ACC_W-1:0] carry_in);
    return (w << SHIFT) | carry_in;
  endfunction

  function automatic logic [EXT_W-1:0] ext_step(input logic [EXT_W-1:0] e,
                                                 input logic [ACC_W-1:0] carry_in);
    return EXT_W'(e << SHIFT) | EXT_W'(carry_in);
  endfunction

  assign ext_nxt = ext_step(ext_cur, top_out(hi_cur));
  assign hi_nxt  = word_step(hi_cur, top_out(lo_cur));
  assign lo_nxt  = word_step(lo_cur, ACC_W'(fill));
endmodule

// File: rtl/acc_state_regs.sv
// Chain storage with synchronous clear and load enable.
module acc_state_regs #(
  parameter int ACC_W = 32,
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [EXT_W-1:0] ext_d,
  input  logic [ACC_W-1:0] hi_d,
  input  logic [ACC_W-1:0] lo_d,
  output logic [EXT_W-1:0] ext_q,
  output logic [ACC_W-1:0] hi_q,
  output logic [ACC_W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (load) begin
      ext_q <= ext_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
    end
  end

  // R1: reset clears every word on the following cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ext_q == '0 && hi_q == '0 && lo_q == '0));

  // R2: without a load the chain is frozen
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(ext_q) && $stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/acc_perm_shifter.sv
module acc_perm_shifter
  import acc_perm_pkg::*;
#(
  parameter int ACC_W = DEF_ACC_W,
  parameter int EXT_W = DEF_EXT_W,
  parameter int LANES = DEF_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [ACC_W-1:0] cmd_src,
  input  logic [ACC_W-1:0] cmd_sel,
  output logic [EXT_W-1:0] ext_q,
  output logic [ACC_W-1:0] hi_q,
  output logic [ACC_W-1:0] lo_q
);
  localparam int IDX_W  = $clog2(ACC_W);
  localparam int USED_W = LANES * IDX_W;

  // Named internal events for the properties below.
  logic             shift_fire;
  logic [LANES-1:0] gather_bits;
  logic [ACC_W-1:0] sel_spare;
  logic [EXT_W-1:0] ext_nxt;
  logic [ACC_W-1:0] hi_nxt;
  logic [ACC_W-1:0] lo_nxt;

  assign shift_fire = cmd_valid & ~rst;
  assign sel_spare  = cmd_sel >> USED_W;

  perm_gather #(.ACC_W(ACC_W), .LANES(LANES)) u_gather (
    .src (cmd_src),
    .sel (cmd_sel),
    .bits(gather_bits)
  );

  acc_chain_shift #(.ACC_W(ACC_W), .EXT_W(EXT_W), .SHIFT(LANES)) u_shift (
    .ext_cur(ext_q),
    .hi_cur (hi_q),
    .lo_cur (lo_q),
    .fill   (gather_bits),
    .ext_nxt(ext_nxt),
    .hi_nxt (hi_nxt),
    .lo_nxt (lo_nxt)
  );

  acc_state_regs #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .load (shift_fire),
    .ext_d(ext_nxt),
    .hi_d (hi_nxt),
    .lo_d (lo_nxt),
    .ext_q(ext_q),
    .hi_q (hi_q),
    .lo_q (lo_q)
  );

  // R3: extension word receives the bits leaving the top of the high word
  a_r3_ext_feed: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> ext_q == (EXT_W'($past(ext_q) << LANES)
                           | EXT_W'($past(hi_q) >> (ACC_W - LANES))));

  // R4: high word receives the bits leaving the top of the low word
  a_r4_hi_feed: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> hi_q == (($past(hi_q) << LANES) | ($past(lo_q) >> (ACC_W - LANES))));

  // R5: upper part of the low word is the old low word moved up
  a_r5_lo_upper: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (lo_q >> LANES) == ($past(lo_q) & ((ACC_W'(1) << (ACC_W - LANES)) - 1)));

  // R6, R8: freshly filled bits are exactly what the gather produced at the sampling edge
  a_r6_fill_from_gather: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> lo_q[LANES-1:0] == $past(gather_bits));

  // R7: spare selector bits never bring in anything other than the gather result
  a_r7_spare_ignored: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && sel_spare != '0) |=> lo_q[LANES-1:0] == $past(gather_bits));
endmodule

// File: tb/acc_perm_shifter_test.sv
`timescale 1ns/1ps
module acc_perm_shifter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [31:0] cmd_src;
  logic [31:0] cmd_sel;
  logic [7:0]  ext_q;
  logic [31:0] hi_q;
  logic [31:0] lo_q;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // Reference chain: one 72-bit value {ext, hi, lo}.
  logic [71:0] ref_chain;

  always #4 clk = ~clk;  // 125 MHz

  acc_perm_shifter uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
    .cmd_src(cmd_src), .cmd_sel(cmd_sel),
    .ext_q(ext_q), .hi_q(hi_q), .lo_q(lo_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural gather: integer index arithmetic, little-endian bit numbering.
  function automatic logic [5:0] model_gather(input logic [31:0] s, input logic [31:0] k);
    logic [5:0] r = '0;
    for (int i = 0; i < 6; i++) begin
      int pos = int'((k >> (5 * i)) % 32);
      r[i] = (s >> pos) & 1;
    end
    return r;
  endfunction

  // Expected chain after the next edge for the inputs now being driven.
  task automatic model_step();
    if (rst) ref_chain = '0;
    else if (cmd_valid) ref_chain = (ref_chain << 6) | 72'(model_gather(cmd_src, cmd_sel));
  endtask

  // Compare every part of the chain; tag names the requirement under test.
  task automatic compare_all(input string tag);
    check({tag, "/R3 ext"}, {24'd0, ext_q}, {24'd0, ref_chain[71:64]});
    check({tag, "/R4 hi"}, hi_q, ref_chain[63:32]);
    check({tag, "/R5 lo upper"}, lo_q & 32'hFFFF_FFC0, ref_chain[31:0] & 32'hFFFF_FFC0);
    check({tag, "/R6 lo fill"}, {26'd0, lo_q[5:0]}, {26'd0, ref_chain[5:0]});
  endtask

  // Drive one cycle: set inputs at negedge, let the edge pass, compare at next negedge.
  task automatic cycle(input string tag, input logic r, input logic v,
                       input logic [31:0] s, input logic [31:0] k);
    rst = r; cmd_valid = v; cmd_src = s; cmd_sel = k;
    model_step();
    @(negedge clk);
    compare_all(tag);
  endtask

  function automatic logic [31:0] pack_idx(input int a, input int b, input int c,
                                          input int d, input int e, input int f);
    return 32'(a) | (32'(b) << 5) | (32'(c) << 10) | (32'(d) << 15)
         | (32'(e) << 20) | (32'(f) << 25);
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0]  fill_a;
    logic [31:0] rnd;
    rst = 1'b1; cmd_valid = 1'b0; cmd_src = '0; cmd_sel = '0;
    ref_chain = '0;
    @(negedge clk);
    // R1: reset state, even with a command present
    cycle("R1 reset", 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0);
    check("R1 zero ext", {24'd0, ext_q}, 32'd0);
    check("R1 zero lo", lo_q, 32'd0);

    // R6: index 0 and 31 boundaries, little-endian numbering
    cycle("R6 idx0", 1'b0, 1'b1, 32'h0000_0001, pack_idx(0, 1, 0, 1, 0, 1));
    check("R6 idx0 pattern", {26'd0, lo_q[5:0]}, 32'h15);
    cycle("R6 idx31", 1'b0, 1'b1, 32'h8000_0000, pack_idx(31, 31, 30, 31, 0, 31));
    check("R6 idx31 pattern", {26'd0, lo_q[5:0]}, 32'h2B);

    // R8: five back-to-back permutes carrying bits through the whole chain
    cycle("R8 p1", 1'b0, 1'b1, 32'hDEAD_BEEF, pack_idx(3, 7, 11, 19, 23, 29));
    cycle("R8 p2", 1'b0, 1'b1, 32'h1234_5678, pack_idx(1, 2, 4, 8, 16, 31));
    cycle("R8 p3", 1'b0, 1'b1, 32'hFFFF_FFFF, pack_idx(5, 5, 5, 5, 5, 5));
    cycle("R8 p4", 1'b0, 1'b1, 32'hA5A5_A5A5, pack_idx(0, 1, 2, 3, 4, 5));
    cycle("R8 p5", 1'b0, 1'b1, 32'h0F0F_0F0F, pack_idx(31, 27, 4, 8, 12, 0));

    // R2: idle cycles with changing operands leave the chain untouched
    cycle("R2 idle", 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h3FFF_FFFF);
    cycle("R2 idle", 1'b0, 1'b0, 32'h0, 32'h0);

    // R7: same operands with and without spare selector bits give the same fill
    cycle("R7 base", 1'b0, 1'b1, 32'h6C3A_91E5, pack_idx(9, 14, 2, 30, 17, 6));
    fill_a = lo_q[5:0];
    cycle("R7 spare", 1'b0, 1'b1, 32'h6C3A_91E5, pack_idx(9, 14, 2, 30, 17, 6) | 32'hC000_0000);
    check("R7 spare bits ignored", {26'd0, lo_q[5:0]}, {26'd0, fill_a});

    // R1: reset in the middle of a run wins over a command
    cycle("R1 midrun", 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0);
    check("R1 midrun hi", hi_q, 32'd0);

    // Random stream, compared every clock
    rnd = 32'h1357_9BDF;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] s, k;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      s = rnd;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      k = rnd;
      cycle("R8 random", (n % 97) == 96, (k[31:29] != 3'b000), s, k);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule